// File: doc/BRIEF.md
# L2 Cluster Power-Up Sequencer

This block brings a shared cluster cache and its snoop-control arrays out of power-off. It is a timed state machine that drives a 32-bit packed power-control word, a debug-reset override bit and a two-bit clock-branch control. A one-cycle start pulse begins the run. At that moment the head-switch status input is sampled. If the cache already reports power, the run is skipped at once. Otherwise the block walks through clamping, array head-switch enable, clock enable, reset release and a final hand-over. It waits a fixed number of microseconds between steps. The parameter `CYC_PER_US` turns those waits into clock cycles.

The states are `ST_IDLE`, `ST_CLAMP`, `ST_UNCLAMP`, `ST_ARRAYS`, `ST_CLOCK` and `ST_RELEASE`. The transitions are as follows:

- **IDLE to IDLE (skip):** start with status high.
- **IDLE to CLAMP (entry):** start with status low.
- **CLAMP to UNCLAMP:** the 2 us wait has elapsed.
- **UNCLAMP to ARRAYS:** always, after one cycle.
- **ARRAYS to CLOCK:** the 2 us wait has elapsed.
- **CLOCK to RELEASE:** the 2 us wait has elapsed.
- **RELEASE to IDLE (hand-over):** the 54 us wait has elapsed.

Every control value is registered and is held until a later step changes it. So the final values persist after the sequence ends.

Top module: `l2c_pwr_seq`

## Requirements
In the rules below, W2 = 2·CYC_PER_US and W54 = 54·CYC_PER_US.

The control-word bit map is:
- bit 0: L2-array head-switch
- bit 1: SCU-array head-switch
- bit 2: L2 reset disable
- bit 8: head-switch clamp
- bit 9: head-switch enable
- bit 10: head-switch reset
- bit 11: sleep state
- bit 12: system reset
- bit 13: retention sleep
- bit 14: SCU-array clamp
- bit 15: L2-array clamp
- bits [27:16]: head-switch count
- bit 28: PMIC-on

In the clock-branch control, bit 0 is the clock enable and bit 1 is hardware control.

- R1: A synchronous reset clears the control word, the override, the clock-branch control, done and skipped, and returns the machine to idle.
- R2: A start in idle with status high makes done and skipped high in the next cycle and leaves every control output unchanged.
- R3: A start in idle with status low loads the control word 0x0010D700 (count 16) and sets the override, from the next cycle, for W2 cycles. The clock-branch control is untouched.
- R4: The word then reads 0x00101700 for exactly one cycle, then 0x00101703 for W2 cycles.
- R5: Next, the word reads 0x00101603 and the clock-branch control reads 01, for W2 cycles.
- R6: Next, the override drops to 0 and the word reads 0x00100203, for W54 cycles.
- R7: At the end the word becomes 0x10100203, the clock-branch control becomes 11 and done is high. These values hold until a later start or reset.
- R8: A start while a run is in progress has no effect on any output.
- R9: Done is high for exactly one cycle per completed or skipped request.
- R10: Bits 2, 11, 13 and bits [31:29] of the control word are always 0.
- R11: Skipped stays high after a skip until a start that runs the full sequence, which clears it together with the first step.
- R12: Status is sampled only at an accepted start; changes during a run have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request pulse |
| hs_status_i | input | 1 | Head-switch status: cache already powered |
| done_o | output | 1 | One-cycle completion pulse |
| skipped_o | output | 1 | Last request was skipped |
| l2_ctl_o | output | 32 | Packed cache power-control word |
| dbg_rst_ovr_o | output | 1 | Debug-reset override |
| clk_branch_o | output | 2 | Clock-branch control: bit 0 enable, bit 1 hardware control |

## Verification
A wrong state or a slipped timer shows first as a control word that changes one or more cycles too early or too late. A reference model that counts the cycles of each phase catches this on the very clock it happens. A lost skip decision shows in the cycle after start, as a control word that moves away from its prior value. A stuck machine shows as a missing done after the expected 3·W2+W54+1 cycles. Starts and status toggles during a run probe that the state advances only on its own timer.

// File: rtl/l2c_pwr_pkg.sv
package l2c_pwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLAMP,
        ST_UNCLAMP,
        ST_ARRAYS,
        ST_CLOCK,
        ST_RELEASE
    } l2c_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_ENTRY,
        ACT_UNCLAMP,
        ACT_ARRAYS,
        ACT_CLOCK,
        ACT_RELEASE,
        ACT_HANDOFF
    } l2c_act_e;

    localparam int CTL_W        = 32;
    localparam int B_L2_ARR_HS  = 0;
    localparam int B_SCU_ARR_HS = 1;
    localparam int B_HS_CLAMP   = 8;
    localparam int B_HS_EN      = 9;
    localparam int B_HS_RST     = 10;
    localparam int B_SYS_RST    = 12;
    localparam int B_SCU_CLAMP  = 14;
    localparam int B_L2_CLAMP   = 15;
    localparam int B_CNT_LO     = 16;
    localparam int CNT_W        = 12;
    localparam int B_PMIC_ON    = 28;

    localparam int CLK_B_EN     = 0;
    localparam int CLK_B_HW     = 1;

endpackage

// File: rtl/l2c_wait_timer.sv
module l2c_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R3..R6 waits: the count falls by exactly one per cycle unless reloaded
    p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/l2c_seq_fsm.sv
module l2c_seq_fsm
    import l2c_pwr_pkg::*;
#(
    parameter int TMR_W      = 8,
    parameter int WAIT_SHORT = 2,
    parameter int WAIT_LONG  = 54
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             hs_status_i,
    input  logic             expired_i,
    output logic             load_o,
    output logic [TMR_W-1:0] load_val_o,
    output l2c_act_e         act_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             skipped_o
);
    localparam logic [TMR_W-1:0] SHORT_RELOAD = TMR_W'(WAIT_SHORT - 1);
    localparam logic [TMR_W-1:0] LONG_RELOAD  = TMR_W'(WAIT_LONG - 1);

    l2c_state_e state_q, state_d;
    logic       skip_evt;
    logic       done_q, skipped_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state, step action and timer load
    always_comb begin
        state_d    = state_q;
        act_o      = ACT_NONE;
        load_o     = 1'b0;
        load_val_o = SHORT_RELOAD;
        skip_evt   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (hs_status_i) begin
                        skip_evt = 1'b1;
                    end else begin
                        state_d = ST_CLAMP;
                        act_o   = ACT_ENTRY;
                        load_o  = 1'b1;
                    end
                end
            end
            ST_CLAMP: begin
                if (expired_i) begin
                    state_d = ST_UNCLAMP;
                    act_o   = ACT_UNCLAMP;
                end
            end
            ST_UNCLAMP: begin
                state_d = ST_ARRAYS;
                act_o   = ACT_ARRAYS;
                load_o  = 1'b1;
            end
            ST_ARRAYS: begin
                if (expired_i) begin
                    state_d = ST_CLOCK;
                    act_o   = ACT_CLOCK;
                    load_o  = 1'b1;
                end
            end
            ST_CLOCK: begin
                if (expired_i) begin
                    state_d    = ST_RELEASE;
                    act_o      = ACT_RELEASE;
                    load_o     = 1'b1;
                    load_val_o = LONG_RELOAD;
                end
            end
            ST_RELEASE: begin
                if (expired_i) begin
                    state_d = ST_IDLE;
                    act_o   = ACT_HANDOFF;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // completion flags
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q    <= 1'b0;
            skipped_q <= 1'b0;
        end else begin
            done_q <= skip_evt || (act_o == ACT_HANDOFF);
            if (skip_evt) begin
                skipped_q <= 1'b1;
            end else if (act_o == ACT_ENTRY) begin
                skipped_q <= 1'b0;
            end
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign skipped_o = skipped_q;

    // R9: done never lasts two cycles
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R4: the unclamp state lasts exactly one cycle
    p_unclamp_one_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UNCLAMP) |=> (state_q == ST_ARRAYS));

    // R8: a busy machine never returns to the entry step
    p_busy_no_reentry_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE && state_q != ST_RELEASE) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/l2c_ctl_regs.sv
module l2c_ctl_regs
    import l2c_pwr_pkg::*;
#(
    parameter int HS_COUNT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  l2c_act_e         act_i,
    output logic [CTL_W-1:0] l2_ctl_o,
    output logic             dbg_ovr_o,
    output logic [1:0]       clk_branch_o
);
    localparam logic [CNT_W-1:0] CNT_VAL = CNT_W'(HS_COUNT);
    localparam logic [CTL_W-1:0] USED_MASK =
        (CTL_W'(1) << B_L2_ARR_HS) | (CTL_W'(1) << B_SCU_ARR_HS) |
        (CTL_W'(1) << B_HS_CLAMP)  | (CTL_W'(1) << B_HS_EN) |
        (CTL_W'(1) << B_HS_RST)    | (CTL_W'(1) << B_SYS_RST) |
        (CTL_W'(1) << B_SCU_CLAMP) | (CTL_W'(1) << B_L2_CLAMP) |
        (CTL_W'({CNT_W{1'b1}}) << B_CNT_LO) | (CTL_W'(1) << B_PMIC_ON);

    logic [CTL_W-1:0] ctl_q;
    logic             ovr_q;
    logic [1:0]       cbr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ovr_q <= 1'b0;
            cbr_q <= 2'b00;
        end else begin
            unique case (act_i)
                ACT_ENTRY: begin
                    ctl_q                            <= '0;
                    ctl_q[B_HS_CLAMP]                <= 1'b1;
                    ctl_q[B_HS_EN]                   <= 1'b1;
                    ctl_q[B_HS_RST]                  <= 1'b1;
                    ctl_q[B_SYS_RST]                 <= 1'b1;
                    ctl_q[B_SCU_CLAMP]               <= 1'b1;
                    ctl_q[B_L2_CLAMP]                <= 1'b1;
                    ctl_q[B_CNT_LO +: CNT_W]         <= CNT_VAL;
                    ovr_q                            <= 1'b1;
                end
                ACT_UNCLAMP: begin
                    ctl_q[B_SCU_CLAMP] <= 1'b0;
                    ctl_q[B_L2_CLAMP]  <= 1'b0;
                end
                ACT_ARRAYS: begin
                    ctl_q[B_L2_ARR_HS]  <= 1'b1;
                    ctl_q[B_SCU_ARR_HS] <= 1'b1;
                end
                ACT_CLOCK: begin
                    ctl_q[B_HS_CLAMP] <= 1'b0;
                    cbr_q[CLK_B_EN]   <= 1'b1;
                    cbr_q[CLK_B_HW]   <= 1'b0;
                end
                ACT_RELEASE: begin
                    ctl_q[B_HS_RST]  <= 1'b0;
                    ctl_q[B_SYS_RST] <= 1'b0;
                    ovr_q            <= 1'b0;
                end
                ACT_HANDOFF: begin
                    ctl_q[B_PMIC_ON] <= 1'b1;
                    cbr_q[CLK_B_EN]  <= 1'b1;
                    cbr_q[CLK_B_HW]  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign l2_ctl_o     = ctl_q;
    assign dbg_ovr_o    = ovr_q;
    assign clk_branch_o = cbr_q;

    // R10: bits outside the driven set stay low
    p_reserved_low_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl_q & ~USED_MASK) == '0);

    // R7: hardware clock control only ever appears with the clock enabled
    p_hw_needs_en_r7: assert property (@(posedge clk) disable iff (rst)
        cbr_q[CLK_B_HW] |-> cbr_q[CLK_B_EN]);

    // R6: the debug override is never held without the system reset
    p_ovr_within_sysrst_r6: assert property (@(posedge clk) disable iff (rst)
        ovr_q |-> ctl_q[B_SYS_RST]);

endmodule

// File: rtl/l2c_pwr_seq.sv
module l2c_pwr_seq
    import l2c_pwr_pkg::*;
#(
    parameter int CYC_PER_US = 125,
    parameter int HS_COUNT   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        hs_status_i,
    output logic        done_o,
    output logic        skipped_o,
    output logic [31:0] l2_ctl_o,
    output logic        dbg_rst_ovr_o,
    output logic [1:0]  clk_branch_o
);
    localparam int WAIT_SHORT = 2 * CYC_PER_US;
    localparam int WAIT_LONG  = 54 * CYC_PER_US;
    localparam int TMR_W      = $clog2(WAIT_LONG + 1);

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_expired;
    l2c_act_e         act;
    logic             busy;

    l2c_wait_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_expired)
    );

    l2c_seq_fsm #(
        .TMR_W      (TMR_W),
        .WAIT_SHORT (WAIT_SHORT),
        .WAIT_LONG  (WAIT_LONG)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .hs_status_i (hs_status_i),
        .expired_i   (tmr_expired),
        .load_o      (tmr_load),
        .load_val_o  (tmr_val),
        .act_o       (act),
        .busy_o      (busy),
        .done_o      (done_o),
        .skipped_o   (skipped_o)
    );

    l2c_ctl_regs #(.HS_COUNT(HS_COUNT)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .act_i        (act),
        .l2_ctl_o     (l2_ctl_o),
        .dbg_ovr_o    (dbg_rst_ovr_o),
        .clk_branch_o (clk_branch_o)
    );

    // R2: a skipped request reports done and skipped and touches no control
    p_skip_keeps_ctl_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i && hs_status_i) |=>
            (done_o && skipped_o && $stable(l2_ctl_o) &&
             $stable(clk_branch_o) && $stable(dbg_rst_ovr_o)));

    // R3: an accepted run begins with the override set and clamps applied
    p_entry_word_r3: assert property (@(posedge clk) disable iff (rst)
        (!busy && start_i && !hs_status_i) |=>
            (dbg_rst_ovr_o && l2_ctl_o[B_HS_CLAMP] && l2_ctl_o[B_L2_CLAMP] && !skipped_o));

endmodule

// File: tb/sim_l2c_pwr_seq.sv
module sim_l2c_pwr_seq;
    localparam int CPU = 3;
    localparam int N2  = 2 * CPU;
    localparam int N54 = 54 * CPU;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        status = 1'b0;
    logic        done, skipped, dbg;
    logic [31:0] ctl;
    logic [1:0]  cbr;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 0;

    // reference model state
    int          m_phase = 0;
    int          m_left = 0;
    logic [31:0] m_ctl = '0;
    logic        m_dbg = 1'b0;
    logic [1:0]  m_cbr = 2'b00;
    logic        m_done = 1'b0;
    logic        m_skip = 1'b0;
    string       m_tag = "R1";

    always #4 clk = ~clk;

    l2c_pwr_seq #(.CYC_PER_US(CPU), .HS_COUNT(16)) u0 (
        .clk(clk), .rst(rst), .start_i(start), .hs_status_i(status),
        .done_o(done), .skipped_o(skipped), .l2_ctl_o(ctl),
        .dbg_rst_ovr_o(dbg), .clk_branch_o(cbr)
    );

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_phase = 0; m_left = 0; m_ctl = '0; m_dbg = 0; m_cbr = 0;
            m_done = 0; m_skip = 0; m_tag = "R1";
        end else begin
            m_done = 0;
            case (m_phase)
                0: if (start) begin
                    if (status) begin
                        m_done = 1; m_skip = 1; m_tag = "R2";
                    end else begin
                        m_phase = 1; m_left = N2; m_ctl = 32'h0010D700;
                        m_dbg = 1; m_skip = 0; m_tag = "R3";
                    end
                end
                1: begin
                    m_left--;
                    if (m_left == 0) begin m_phase = 2; m_ctl = 32'h00101700; m_tag = "R4"; end
                end
                2: begin m_phase = 3; m_left = N2; m_ctl = 32'h00101703; end
                3: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_phase = 4; m_left = N2; m_ctl = 32'h00101603; m_cbr = 2'b01; m_tag = "R5";
                    end
                end
                4: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_phase = 5; m_left = N54; m_ctl = 32'h00100203; m_dbg = 0; m_tag = "R6";
                    end
                end
                5: begin
                    m_left--;
                    if (m_left == 0) begin
                        m_phase = 0; m_ctl = 32'h10100203; m_cbr = 2'b11; m_done = 1; m_tag = "R7";
                    end
                end
                default: m_phase = 0;
            endcase
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            tests++;
            if (ctl !== m_ctl || dbg !== m_dbg || cbr !== m_cbr ||
                done !== m_done || skipped !== m_skip) begin
                fails++;
                $display("FAIL %s cyc %0d: ctl=%h dbg=%b clk=%b done=%b skip=%b expected ctl=%h dbg=%b clk=%b done=%b skip=%b",
                         m_tag, cycles, ctl, dbg, cbr, done, skipped,
                         m_ctl, m_dbg, m_cbr, m_done, m_skip);
            end
            tests++;
            // R10: reserved bits low
            if ((ctl & ~32'h1FFFD703) != 0) begin
                fails++;
                $display("FAIL R10: ctl=%h expected reserved bits 0", ctl);
            end
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic pulse(logic st);
        status = st; start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic expect_now(string tag, logic [31:0] e_ctl, logic e_done);
        @(negedge clk);
        tests++;
        if (ctl !== e_ctl || done !== e_done) begin
            fails++;
            $display("FAIL %s: ctl=%h done=%b expected ctl=%h done=%b", tag, ctl, done, e_ctl, e_done);
        end
        #1;
    endtask

    task automatic run_full();
        int dn;
        dn = 0;
        pulse(1'b0);
        for (int i = 0; i < 3 * N2 + N54 + 4; i++) begin
            @(negedge clk);
            if (done) dn++;
            // R8 / R12: extra starts and status toggles during the run
            if (i == 3) begin #1; start = 1'b1; status = 1'b1; end
            else if (i == N2 + 3) begin #1; start = 1'b1; status = 1'b0; end
            else begin #1; start = 1'b0; end
        end
        start = 1'b0;
        tests++;
        if (dn != 1) begin
            fails++;
            $display("FAIL R9: done pulses=%0d expected 1", dn);
        end
    endtask

    initial begin
        step(3);
        // R1: reset state
        tests++;
        if (ctl !== 0 || dbg !== 0 || cbr !== 0 || done !== 0 || skipped !== 0) begin
            fails++;
            $display("FAIL R1: ctl=%h dbg=%b clk=%b expected all zero", ctl, dbg, cbr);
        end
        rst = 1'b0;
        step(2);
        // R2: skip from reset state
        pulse(1'b1);
        tests++;
        if (!done || !skipped || ctl !== 0) begin
            fails++;
            $display("FAIL R2: done=%b skip=%b ctl=%h expected 1 1 0", done, skipped, ctl);
        end
        step(3);
        // full sequence, R11 clears skipped
        run_full();
        // R7: final values held
        expect_now("R7", 32'h10100203, 1'b0);
        tests++;
        if (cbr !== 2'b11 || dbg !== 1'b0) begin
            fails++;
            $display("FAIL R7: clk=%b dbg=%b expected 11 0", cbr, dbg);
        end
        // R2 after completion: outputs untouched
        pulse(1'b1);
        expect_now("R2", 32'h10100203, 1'b0);
        // rerun with status low: R11 and clock-branch untouched until clock step
        run_full();
        step(4);
        // R1: reset mid-run
        pulse(1'b0);
        step(N2 + 2);
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        tests++;
        if (ctl !== 0 || dbg !== 0 || cbr !== 0) begin
            fails++;
            $display("FAIL R1: ctl=%h dbg=%b clk=%b expected zero after reset", ctl, dbg, cbr);
        end
        step(2);
        run_full();
        step(3);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule